// File: doc/BRIEF.md
# SPI Transmit/Receive FIFO Pair

This block places a word queue on each side of a serial shift engine. The CPU side writes words into the transmit queue. The shift engine takes the oldest transmit word whenever it signals that it is idle. Words that the engine has received go into the receive queue, and the CPU side drains that queue one word per read strobe. Each queue keeps a fill count from 0 to its depth. Each queue also has a programmable level, a sticky level flag that sets when the count equals that level, an interrupt enable and a run bit that flushes the queue while it is low. The receive queue also keeps a sticky overflow flag for words that arrive when no room is left.

A global enable switches the block between queued operation and single-word buffering. In single-word mode each direction accepts only one word, and the level flags and interrupts stay quiet. The state of each direction comes back as a 16-bit status word. Software control arrives as plain level and pulse inputs, so a bus decoder elsewhere maps these onto registers.

Top module: `spi_fifo_unit`

## Requirements
- R1: While rst_n is low at a clock edge, both counts, both level flags and the overflow flag become 0, and tx_irq and rx_irq are 0 after that edge.
- R2: Each status word has this layout. Bits [4:0] hold the count. Bit 5 is the level flag, bit 6 echoes the interrupt enable and bit 7 echoes the run bit. Bits [12:8] echo the level. Bit 13 is the overflow flag, which is always 0 in tx_stat. Bit 14 echoes fifo_en and bit 15 is 0.
- R3: With fifo_en=1, each queue holds up to 16 words in arrival order, and its count ranges from 0 to 16. A tx_wr_vld while the transmit count is 16 is dropped.
- R4: eng_load is high in any cycle where eng_idle=1, tx_run=1 and the transmit count is non-zero. eng_load_data then shows the oldest transmit word, and that word leaves the queue at the next edge.
- R5: Each eng_rx_vld with room stores eng_rx_data. rx_rd_data shows the oldest receive word, and rx_rd removes it at the edge. An rx_rd on an empty queue has no effect.
- R6: A received word that arrives while the receive count is at capacity is discarded and sets the overflow flag. Capacity is judged on the count at the start of the cycle, even when rx_rd pops in that same cycle.
- R7: A rx_ovf_clr pulse clears the overflow flag. If a word is discarded in that same cycle, the flag stays set.
- R8: With fifo_en=1 and the run bit 1, a count equal to the level in one cycle sets that direction's level flag at the next edge. The flag then stays set after the count moves away.
- R9: A flag-clear pulse clears the level flag. If the count still equals the level in that cycle, the flag stays set.
- R10: tx_irq and rx_irq are high exactly when the level flag, the interrupt enable and fifo_en are all 1.
- R11: A run bit of 0 empties its queue at the next edge and drops all pushes and pops. It leaves that direction's flags unchanged.
- R12: With fifo_en=0, each queue accepts only one word. A second transmit write is dropped, a second received word is discarded and sets the overflow flag, and the level flags do not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | 1 = queued mode, 0 = single-word buffering |
| tx_run | input | 1 | Transmit run bit, 0 flushes and holds the queue |
| tx_ie | input | 1 | Transmit interrupt enable |
| tx_lvl | input | 5 | Transmit level for the flag match |
| tx_flag_clr | input | 1 | Pulse, clears the transmit level flag |
| rx_run | input | 1 | Receive run bit, 0 flushes and holds the queue |
| rx_ie | input | 1 | Receive interrupt enable |
| rx_lvl | input | 5 | Receive level for the flag match |
| rx_flag_clr | input | 1 | Pulse, clears the receive level flag |
| rx_ovf_clr | input | 1 | Pulse, clears the receive overflow flag |
| tx_wr_vld | input | 1 | CPU write into the transmit queue |
| tx_wr_data | input | 16 | Word to transmit |
| rx_rd | input | 1 | CPU read strobe, pops the receive queue |
| rx_rd_data | output | 16 | Oldest received word |
| eng_idle | input | 1 | Shift engine can take a word |
| eng_load | output | 1 | Transmit word handed to the engine this cycle |
| eng_load_data | output | 16 | Word handed to the engine |
| eng_rx_vld | input | 1 | Engine finished a received word |
| eng_rx_data | input | 16 | Word received by the engine |
| tx_stat | output | 16 | Transmit status word (layout in R2) |
| rx_stat | output | 16 | Receive status word (layout in R2) |
| tx_irq | output | 1 | Transmit level interrupt request |
| rx_irq | output | 1 | Receive level interrupt request |

## Verification
Two kinds of event can fall on the same edge. A sticky flag can be cleared by software in the same cycle that its set condition holds. A received word can also arrive at a full queue in the same cycle that the CPU reads. The bench provokes the first collision in two ways: it pulses the flag clear while the transmit count still equals the level, and it pulses the overflow clear in the same cycle that a discarded word arrives. In both cases it expects the flag to stay set. It provokes the second collision by raising eng_rx_vld and rx_rd together at a count of 16. It expects the count to drop to 15, the overflow flag to set, and the discarded word never to appear in the read stream.

// File: rtl/spi_fifo_pkg.sv
// Shared constants and the status word type for the SPI FIFO pair.
// Assumes a depth whose count fits the 5-bit count field of the status word.
package spi_fifo_pkg;
    localparam int unsigned FIFO_DATA_W = 16;
    localparam int unsigned FIFO_DEPTH  = 16;
    localparam int unsigned STAT_CNT_W  = 5;
    localparam int unsigned NUM_DIR     = 2;
    localparam int unsigned DIR_TX      = 0;
    localparam int unsigned DIR_RX      = 1;

    // Status word returned for each direction, MSB first.
    typedef struct packed {
        logic                  rsvd;
        logic                  en;
        logic                  ovf;
        logic [STAT_CNT_W-1:0] lvl;
        logic                  run;
        logic                  ie;
        logic                  flag;
        logic [STAT_CNT_W-1:0] cnt;
    } fifo_stat_t;
endpackage

// File: rtl/spi_fifo_store.sv
// Circular word store with a fill count.
// A push is accepted only when there is room, judged on the count at the
// start of the cycle. In single-word mode the room is one word. A run of 0
// empties the store at the next edge and blocks all pushes and pops.
// Assumes DEPTH >= 2.
module spi_fifo_store #(
    parameter  int unsigned DATA_W = 16,
    parameter  int unsigned DEPTH  = 16,
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
    localparam int unsigned PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              single,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              refused
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              full;
    logic              do_push;
    logic              do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Decide which requests take effect this cycle.
    always_comb begin
        full    = single ? (count != '0) : (count == CNT_W'(DEPTH));
        do_push = push && run && !full;
        do_pop  = pop && run && (count != '0);
        refused = push && run && full;
        head    = mem[rd_ptr];
    end

    // Write the accepted word into storage.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Advance pointers and count, or flush on reset or stop.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end
endmodule

// File: rtl/spi_fifo_level_flag.sv
// Sticky level-match flag with write-one clear and a gated interrupt.
// The flag sets one edge after count equals level, and a set in the same
// cycle wins over a clear. Assumes count comes straight from a register.
module spi_fifo_level_flag #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             run,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] level,
    input  logic             clr,
    input  logic             ie,
    output logic             flag,
    output logic             irq
);
    logic hit;

    // Match condition, active only in queued mode while running.
    assign hit = en && run && (count == level);

    // Keep the flag, set on a match, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else begin
            flag <= (flag && !clr) || hit;
        end
    end

    // Interrupt request only when enabled and in queued mode.
    assign irq = flag && ie && en;
endmodule

// File: rtl/spi_fifo_stat_pack.sv
// Packs one direction's count, flags and control echoes into a status word.
// Pure combinational logic. Assumes CNT_W does not exceed the count field.
module spi_fifo_stat_pack
    import spi_fifo_pkg::*;
#(
    parameter int unsigned CNT_W = 5
) (
    input  logic                          [CNT_W-1:0] count,
    input  logic                                      flag,
    input  logic                                      ie,
    input  logic                                      run,
    input  logic                          [CNT_W-1:0] level,
    input  logic                                      ovf,
    input  logic                                      en,
    output logic [$bits(fifo_stat_t)-1:0]             word
);
    fifo_stat_t s;

    // Assemble the status fields.
    always_comb begin
        s.rsvd = 1'b0;
        s.en   = en;
        s.ovf  = ovf;
        s.lvl  = STAT_CNT_W'(level);
        s.run  = run;
        s.ie   = ie;
        s.flag = flag;
        s.cnt  = STAT_CNT_W'(count);
    end

    assign word = s;
endmodule

// File: rtl/spi_fifo_unit.sv
// Transmit and receive FIFO pair between a CPU register front end and an SPI
// shift engine. Both directions come from one generate loop. The receive
// direction adds a sticky overflow flag. Assumes that the engine takes a
// word in the cycle it sees eng_load, and that control inputs are already
// decoded from the bus.
module spi_fifo_unit
    import spi_fifo_pkg::*;
#(
    parameter  int unsigned DATA_W = FIFO_DATA_W,
    parameter  int unsigned DEPTH  = FIFO_DEPTH,
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
    localparam int unsigned STAT_W = $bits(fifo_stat_t)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              tx_run,
    input  logic              tx_ie,
    input  logic [CNT_W-1:0]  tx_lvl,
    input  logic              tx_flag_clr,
    input  logic              rx_run,
    input  logic              rx_ie,
    input  logic [CNT_W-1:0]  rx_lvl,
    input  logic              rx_flag_clr,
    input  logic              rx_ovf_clr,
    input  logic              tx_wr_vld,
    input  logic [DATA_W-1:0] tx_wr_data,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_rd_data,
    input  logic              eng_idle,
    output logic              eng_load,
    output logic [DATA_W-1:0] eng_load_data,
    input  logic              eng_rx_vld,
    input  logic [DATA_W-1:0] eng_rx_data,
    output logic [STAT_W-1:0] tx_stat,
    output logic [STAT_W-1:0] rx_stat,
    output logic              tx_irq,
    output logic              rx_irq
);
    logic [NUM_DIR-1:0] run_v;
    logic [NUM_DIR-1:0] push_v;
    logic [NUM_DIR-1:0] pop_v;
    logic [NUM_DIR-1:0] clr_v;
    logic [NUM_DIR-1:0] ie_v;
    logic [NUM_DIR-1:0] flag_v;
    logic [NUM_DIR-1:0] irq_v;
    logic [NUM_DIR-1:0] ovf_v;
    logic [NUM_DIR-1:0] refused_v;
    logic [DATA_W-1:0]  pdata_v [NUM_DIR];
    logic [DATA_W-1:0]  head_v  [NUM_DIR];
    logic [CNT_W-1:0]   cnt_v   [NUM_DIR];
    logic [CNT_W-1:0]   lvl_v   [NUM_DIR];
    logic [STAT_W-1:0]  stat_v  [NUM_DIR];

    // Hand the oldest transmit word over whenever the engine is free.
    assign eng_load = eng_idle && tx_run && (cnt_v[DIR_TX] != '0);

    // Route the transmit-side controls into the per-direction vectors.
    assign run_v[DIR_TX]   = tx_run;
    assign ie_v[DIR_TX]    = tx_ie;
    assign clr_v[DIR_TX]   = tx_flag_clr;
    assign lvl_v[DIR_TX]   = tx_lvl;
    assign push_v[DIR_TX]  = tx_wr_vld;
    assign pdata_v[DIR_TX] = tx_wr_data;
    assign pop_v[DIR_TX]   = eng_load;

    // Route the receive-side controls into the per-direction vectors.
    assign run_v[DIR_RX]   = rx_run;
    assign ie_v[DIR_RX]    = rx_ie;
    assign clr_v[DIR_RX]   = rx_flag_clr;
    assign lvl_v[DIR_RX]   = rx_lvl;
    assign push_v[DIR_RX]  = eng_rx_vld;
    assign pdata_v[DIR_RX] = eng_rx_data;
    assign pop_v[DIR_RX]   = rx_rd;

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        spi_fifo_store #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH)
        ) u_store (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run_v[d]),
            .single    (!fifo_en),
            .push      (push_v[d]),
            .push_data (pdata_v[d]),
            .pop       (pop_v[d]),
            .head      (head_v[d]),
            .count     (cnt_v[d]),
            .refused   (refused_v[d])
        );

        spi_fifo_level_flag #(
            .CNT_W (CNT_W)
        ) u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (fifo_en),
            .run   (run_v[d]),
            .count (cnt_v[d]),
            .level (lvl_v[d]),
            .clr   (clr_v[d]),
            .ie    (ie_v[d]),
            .flag  (flag_v[d]),
            .irq   (irq_v[d])
        );

        if (d == DIR_RX) begin : g_ovf
            logic ovf_q;
            // Sticky overflow on a discarded arrival, where a new set beats a clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ovf_q <= 1'b0;
                end else begin
                    ovf_q <= (ovf_q && !rx_ovf_clr) || refused_v[d];
                end
            end
            assign ovf_v[d] = ovf_q;
        end else begin : g_no_ovf
            // Dropped transmit writes are silent by design.
            logic refused_unused;
            assign refused_unused = refused_v[d];
            assign ovf_v[d]       = 1'b0;
        end

        spi_fifo_stat_pack #(
            .CNT_W (CNT_W)
        ) u_pack (
            .count (cnt_v[d]),
            .flag  (flag_v[d]),
            .ie    (ie_v[d]),
            .run   (run_v[d]),
            .level (lvl_v[d]),
            .ovf   (ovf_v[d]),
            .en    (fifo_en),
            .word  (stat_v[d])
        );
    end

    // Present the per-direction results on the ports.
    assign eng_load_data = head_v[DIR_TX];
    assign rx_rd_data    = head_v[DIR_RX];
    assign tx_stat       = stat_v[DIR_TX];
    assign rx_stat       = stat_v[DIR_RX];
    assign tx_irq        = irq_v[DIR_TX];
    assign rx_irq        = irq_v[DIR_RX];
endmodule

// File: rtl/spi_fifo_unit_chk.sv
// Temporal checks on the FIFO pair, using only the ports of the top module.
// Attached to every spi_fifo_unit instance through the bind at the bottom.
module spi_fifo_unit_chk
    import spi_fifo_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        fifo_en,
    input logic        tx_run,
    input logic        rx_run,
    input logic [4:0]  tx_lvl,
    input logic        tx_flag_clr,
    input logic        tx_wr_vld,
    input logic        eng_load,
    input logic        eng_rx_vld,
    input logic [15:0] tx_stat,
    input logic [15:0] rx_stat,
    input logic        tx_irq,
    input logic        rx_irq
);
    fifo_stat_t ts;
    fifo_stat_t rs;
    assign ts = tx_stat;
    assign rs = rx_stat;

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ts.cnt <= 5'(FIFO_DEPTH)) && (rs.cnt <= 5'(FIFO_DEPTH)));

    // R4
    load_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_load && !tx_wr_vld && tx_run) |=> (ts.cnt == $past(ts.cnt) - 5'd1));

    // R6
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_vld && rx_run && fifo_en && rs.cnt == 5'(FIFO_DEPTH)) |=> rs.ovf);

    // R8
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ts.flag) |-> ($past(ts.cnt) == $past(tx_lvl)) && $past(fifo_en));

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flag_clr && ts.cnt != tx_lvl) |=> !ts.flag);

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> (!tx_irq && !rx_irq));

    // R11
    run_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_run |=> (ts.cnt == 5'd0));

    // R12
    single_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && tx_run && ts.cnt != 5'd0 && !eng_load) |=> (ts.cnt == $past(ts.cnt)));
endmodule

bind spi_fifo_unit spi_fifo_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_en     (fifo_en),
    .tx_run      (tx_run),
    .rx_run      (rx_run),
    .tx_lvl      (tx_lvl),
    .tx_flag_clr (tx_flag_clr),
    .tx_wr_vld   (tx_wr_vld),
    .eng_load    (eng_load),
    .eng_rx_vld  (eng_rx_vld),
    .tx_stat     (tx_stat),
    .rx_stat     (rx_stat),
    .tx_irq      (tx_irq),
    .rx_irq      (rx_irq)
);

// File: tb/tb_spi_fifo_unit.sv
// Scoreboard bench: driver tasks queue the expected words, and the monitors
// compare the handed-over and read words as they appear.
module tb_spi_fifo_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        fifo_en, tx_run, tx_ie, tx_flag_clr;
    logic        rx_run, rx_ie, rx_flag_clr, rx_ovf_clr;
    logic [4:0]  tx_lvl, rx_lvl;
    logic        tx_wr_vld, rx_rd, eng_idle, eng_load, eng_rx_vld;
    logic [15:0] tx_wr_data, rx_rd_data, eng_load_data, eng_rx_data;
    logic [15:0] tx_stat, rx_stat;
    logic        tx_irq, rx_irq;

    always #5 clk = ~clk;

    spi_fifo_unit dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .tx_run(tx_run), .tx_ie(tx_ie), .tx_lvl(tx_lvl), .tx_flag_clr(tx_flag_clr),
        .rx_run(rx_run), .rx_ie(rx_ie), .rx_lvl(rx_lvl), .rx_flag_clr(rx_flag_clr),
        .rx_ovf_clr(rx_ovf_clr), .tx_wr_vld(tx_wr_vld), .tx_wr_data(tx_wr_data),
        .rx_rd(rx_rd), .rx_rd_data(rx_rd_data), .eng_idle(eng_idle),
        .eng_load(eng_load), .eng_load_data(eng_load_data),
        .eng_rx_vld(eng_rx_vld), .eng_rx_data(eng_rx_data),
        .tx_stat(tx_stat), .rx_stat(rx_stat), .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    int tx_drained = 0;
    logic [15:0] tx_exp[$];
    logic [15:0] rx_exp[$];

    // Expected status word, using the layout given in R2.
    function automatic logic [15:0] stat(int cnt, bit flag, bit ie, bit run,
                                         int lvl, bit ovf, bit en);
        return {1'b0, en, ovf, 5'(lvl), run, ie, flag, 5'(cnt)};
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic look();
        #3;
    endtask

    task automatic tx_push(logic [15:0] d, bit accept);
        @(negedge clk);
        tx_wr_vld = 1'b1;
        tx_wr_data = d;
        if (accept) tx_exp.push_back(d);
        @(negedge clk);
        tx_wr_vld = 1'b0;
    endtask

    task automatic rx_send(logic [15:0] d, bit accept);
        @(negedge clk);
        eng_rx_vld = 1'b1;
        eng_rx_data = d;
        if (accept) rx_exp.push_back(d);
        @(negedge clk);
        eng_rx_vld = 1'b0;
    endtask

    task automatic cpu_read();
        @(negedge clk);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    // Monitors: compare handed-over and read words against the queues.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (rst_n === 1'b1 && eng_load === 1'b1) begin
                tx_drained++;
                if (tx_exp.size() == 0) begin
                    n_chk++;
                    n_bad++;
                    $display("FAIL R4 unexpected handover: actual %0h expected none", eng_load_data);
                end else begin
                    check("R4", "handed word", eng_load_data, tx_exp.pop_front());
                end
            end
            if (rst_n === 1'b1 && rx_rd === 1'b1 && rx_stat[4:0] != 5'd0) begin
                if (rx_exp.size() == 0) begin
                    n_chk++;
                    n_bad++;
                    $display("FAIL R5 unexpected read: actual %0h expected none", rx_rd_data);
                end else begin
                    check("R5", "read word", rx_rd_data, rx_exp.pop_front());
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; fifo_en = 1'b1; tx_run = 1'b1; rx_run = 1'b1;
        tx_ie = 1'b0; rx_ie = 1'b0; tx_lvl = 5'd20; rx_lvl = 5'd20;
        tx_flag_clr = 1'b0; rx_flag_clr = 1'b0; rx_ovf_clr = 1'b0;
        tx_wr_vld = 1'b0; tx_wr_data = '0; rx_rd = 1'b0;
        eng_idle = 1'b0; eng_rx_vld = 1'b0; eng_rx_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        look();
        // R1 and R2: reset state.
        check("R1", "tx_stat after reset", tx_stat, stat(0, 0, 0, 1, 20, 0, 1));
        check("R1", "rx_stat after reset", rx_stat, stat(0, 0, 0, 1, 20, 0, 1));
        check("R1", "irqs after reset", {tx_irq, rx_irq, eng_load}, 3'b000);

        // R3: fill the transmit queue, and drop a write once it is full.
        for (int i = 0; i < 16; i++) tx_push(16'hA000 + 16'(i), 1'b1);
        look();
        check("R3", "tx count full", tx_stat[4:0], 5'd16);
        tx_push(16'hBEEF, 1'b0);
        look();
        check("R3", "tx count after dropped write", tx_stat[4:0], 5'd16);
        // R4: the engine drains the queue in order.
        @(negedge clk);
        eng_idle = 1'b1;
        repeat (20) @(negedge clk);
        look();
        check("R4", "no handover when empty", eng_load, 1'b0);
        check("R4", "words handed over", tx_drained, 16);
        check("R2", "tx_stat drained", tx_stat, stat(0, 0, 0, 1, 20, 0, 1));
        @(negedge clk);
        eng_idle = 1'b0;

        // R5: receive path in order, then a read on an empty queue.
        for (int i = 0; i < 5; i++) rx_send(16'h1100 + 16'(i), 1'b1);
        look();
        check("R5", "rx count", rx_stat[4:0], 5'd5);
        for (int i = 0; i < 5; i++) cpu_read();
        look();
        check("R5", "rx count drained", rx_stat[4:0], 5'd0);
        cpu_read();
        look();
        check("R5", "read on empty", rx_stat, stat(0, 0, 0, 1, 20, 0, 1));

        // R6: an arrival at a full queue collides with a read.
        for (int i = 0; i < 16; i++) rx_send(16'h2200 + 16'(i), 1'b1);
        look();
        check("R6", "rx full no ovf", {rx_stat[13], rx_stat[4:0]}, {1'b0, 5'd16});
        @(negedge clk);
        eng_rx_vld = 1'b1; eng_rx_data = 16'hDEAD; rx_rd = 1'b1;
        @(negedge clk);
        eng_rx_vld = 1'b0; rx_rd = 1'b0;
        look();
        check("R6", "count after collision", rx_stat[4:0], 5'd15);
        check("R6", "ovf after collision", rx_stat[13], 1'b1);
        // R7: a clear in the same cycle as another discard leaves the flag set.
        rx_send(16'h2210, 1'b1);
        @(negedge clk);
        eng_rx_vld = 1'b1; eng_rx_data = 16'hDEAF; rx_ovf_clr = 1'b1;
        @(negedge clk);
        eng_rx_vld = 1'b0; rx_ovf_clr = 1'b0;
        look();
        check("R7", "ovf kept on collision", {rx_stat[13], rx_stat[4:0]}, {1'b1, 5'd16});
        @(negedge clk);
        rx_ovf_clr = 1'b1;
        @(negedge clk);
        rx_ovf_clr = 1'b0;
        look();
        check("R7", "ovf cleared", rx_stat[13], 1'b0);
        for (int i = 0; i < 16; i++) cpu_read();
        look();
        check("R6", "discarded words never read", rx_exp.size(), 0);

        // R8, R9, R10: transmit level flag.
        @(negedge clk);
        tx_lvl = 5'd3;
        for (int i = 0; i < 3; i++) tx_push(16'h3300 + 16'(i), 1'b1);
        look();
        check("R8", "flag not yet set", {tx_stat[5], tx_stat[4:0]}, {1'b0, 5'd3});
        @(negedge clk);
        look();
        check("R8", "flag set one edge later", tx_stat[5], 1'b1);
        check("R10", "irq masked", tx_irq, 1'b0);
        @(negedge clk);
        tx_ie = 1'b1;
        look();
        check("R10", "irq enabled", tx_irq, 1'b1);
        @(negedge clk);
        tx_flag_clr = 1'b1;
        @(negedge clk);
        tx_flag_clr = 1'b0;
        look();
        check("R9", "set beats clear", tx_stat[5], 1'b1);
        tx_push(16'h3303, 1'b1);
        look();
        check("R8", "flag sticky past level", {tx_stat[5], tx_stat[4:0]}, {1'b1, 5'd4});
        @(negedge clk);
        tx_flag_clr = 1'b1;
        @(negedge clk);
        tx_flag_clr = 1'b0;
        look();
        check("R9", "flag cleared", {tx_stat[5], tx_irq}, 2'b00);

        // R11: stop flushes the queue and keeps the flag.
        @(negedge clk);
        tx_lvl = 5'd4;
        @(negedge clk);
        tx_run = 1'b0;
        @(negedge clk);
        tx_exp.delete();
        look();
        check("R11", "flushed, flag kept", tx_stat, stat(0, 1, 1, 0, 4, 0, 1));
        tx_push(16'h4444, 1'b0);
        look();
        check("R11", "push while stopped", tx_stat[4:0], 5'd0);
        @(negedge clk);
        tx_run = 1'b1; tx_lvl = 5'd20; tx_flag_clr = 1'b1;
        @(negedge clk);
        tx_flag_clr = 1'b0;

        // R8 and R10: receive level flag.
        @(negedge clk);
        rx_lvl = 5'd2; rx_ie = 1'b1;
        rx_send(16'h5100, 1'b1);
        rx_send(16'h5101, 1'b1);
        @(negedge clk);
        look();
        check("R8", "rx flag", {rx_stat[5], rx_irq}, 2'b11);
        cpu_read();
        cpu_read();
        @(negedge clk);
        rx_flag_clr = 1'b1;
        @(negedge clk);
        rx_flag_clr = 1'b0;
        look();
        check("R9", "rx flag cleared", {rx_stat[5], rx_irq}, 2'b00);

        // R12: single-word mode.
        @(negedge clk);
        fifo_en = 1'b0; tx_lvl = 5'd1; rx_lvl = 5'd1;
        tx_push(16'h5500, 1'b1);
        tx_push(16'h5501, 1'b0);
        look();
        check("R12", "tx single capacity", tx_stat[4:0], 5'd1);
        @(negedge clk);
        look();
        check("R12", "no flag in single mode", {tx_stat[5], tx_irq, tx_stat[14]}, 3'b000);
        rx_send(16'h6600, 1'b1);
        rx_send(16'h6601, 1'b0);
        look();
        check("R12", "rx single capacity and ovf", {rx_stat[13], rx_stat[4:0]}, {1'b1, 5'd1});
        @(negedge clk);
        eng_idle = 1'b1;
        repeat (3) @(negedge clk);
        eng_idle = 1'b0;
        cpu_read();
        look();
        check("R12", "both queues drained", {tx_stat[4:0], rx_stat[4:0]}, 10'd0);
        check("R12", "all words compared", tx_exp.size() + rx_exp.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule